// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an internal request port and an external asynchronous static RAM of 128K bytes. The RAM has an active-low chip select, an active-low write strobe, an active-low output gate and one shared 8-bit data bus. A client presents one read or one write at a time on a ready/valid port. The controller then produces the RAM strobes in the right order and holds each phase for enough clock cycles to meet the RAM's timing limits. It returns read data together with a single-cycle valid pulse.

All wait counts are worked out at elaboration from two parameters: the clock period in nanoseconds and the RAM speed grade (8, 10, 12, 15 or 20 ns). The controller keeps its own data drivers off while the RAM may still be driving the bus. After every read it holds a release phase, so that the RAM outputs have reached high impedance before a later write drives the bus. The bidirectional pad is split into separate output, output-enable and input ports, and the pad ring joins them.

Top module: `sram_ctl`

## Requirements
- R1: Whenever the controller is idle (`req_ready` high), `sram_ce_n`, `sram_we_n` and `sram_oe_n` are all 1 and `sram_dq_oe` is 0.
- R2: A read holds `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for exactly RD = max(1, ceil(grade/T), ceil(tOE/T)) cycles, starting in the cycle after the request is accepted. T is the clock period, and tOE is 5, 5, 6, 7 or 8 ns for grades 8, 10, 12, 15 and 20.
- R3: The word on the data bus at the clock edge that ends the read strobe appears on `rdata`, with `rdata_valid` high for exactly one cycle, in the cycle after the last read-strobe cycle.
- R4: After a read, all strobes stay inactive for HZ = max(1, ceil(tHZ/T)) cycles before `req_ready` returns, where tHZ is 4, 5, 6, 7 or 8 ns for grades 8 to 20. `sram_dq_oe` is never 1 while `sram_oe_n` is 0.
- R5: A write holds `sram_ce_n`=0, `sram_we_n`=0, `sram_oe_n`=1 and `sram_dq_oe`=1 for exactly WR = max(1, ceil(grade/T)) cycles, starting in the cycle after acceptance.
- R6: When `sram_we_n` rises, `sram_ce_n` stays 0 and `sram_dq_oe` stays 1 with unchanged data for that one cycle. All three then return to idle, so a write keeps `req_ready` low for WR+1 cycles.
- R7: A request is accepted only when `req_valid` and `req_ready` are both high at a clock edge. A request raised while the controller is busy and dropped before it is idle starts no access and writes no data.
- R8: `sram_addr` equals the accepted request address in every cycle where `sram_ce_n` is 0.
- R9: A read returns the data of the most recent accepted write to the same address, across arbitrary mixes of reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_valid | output | 1 | One-cycle read-data strobe |
| sram_addr | output | 17 | RAM address pins |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output gate, active low |
| sram_dq_out | output | 8 | Data toward the RAM |
| sram_dq_oe | output | 1 | Enable of the controller's data drivers |
| sram_dq_in | input | 8 | Data from the RAM |

## Verification
The hardest case to reach is a write that follows a read within a few cycles. At that point the RAM may still be driving the bus during its release time while the controller is about to turn its own drivers on. The bench attaches a RAM model that is timed in nanoseconds. The model keeps driving for the full high-impedance time after its output gate closes, and it returns inverted data until the access and gate times have both elapsed. Random mixes of reads and writes over a small set of addresses, plus directed read-then-write pairs, check for bus contention every nanosecond.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_REL,
        ST_WR_PULSE,
        ST_WR_END
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drv;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

    function automatic strobe_t strobes_for(seq_state_e s);
        strobe_t r;
        r = STROBE_IDLE;
        case (s)
            ST_RD_ACC:   begin r.ce_n = 1'b0; r.oe_n = 1'b0; end
            ST_WR_PULSE: begin r.ce_n = 1'b0; r.we_n = 1'b0; r.drv = 1'b1; end
            ST_WR_END:   begin r.ce_n = 1'b0; r.drv = 1'b1; end
            default:     r = STROBE_IDLE;
        endcase
        return r;
    endfunction

    function automatic int ceil_div(int num, int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Output-gate access time for a given speed grade.
    function automatic int gate_access_ns(int grade_ns);
        case (grade_ns)
            8, 10:   return 5;
            12:      return 6;
            15:      return 7;
            default: return 8;
        endcase
    endfunction

    // Gate-high to outputs released, worst case, per speed grade.
    function automatic int release_ns(int grade_ns);
        case (grade_ns)
            8:       return 4;
            10:      return 5;
            12:      return 6;
            15:      return 7;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/sram_ctl_waitcnt.sv
`timescale 1ns/1ps
module sram_ctl_waitcnt #(
    parameter int W    = 4,
    parameter int MAXV = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R2/R5: the phase counter never exceeds the longest programmed wait
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= MAXV);
endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC = 3,
    parameter int WR_CYC = 3,
    parameter int HZ_CYC = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    req_write,
    output logic    req_ready,
    output logic    accept,
    output logic    capture,
    output strobe_t strobe_q
);
    localparam int MAXC = max_of(max_of(RD_CYC, WR_CYC), HZ_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_e state_q, state_d;
    logic       cnt_load, cnt_zero;
    logic [CW-1:0] cnt_val;

    sram_ctl_waitcnt #(.W(CW), .MAXV(MAXC - 1)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state_q == ST_RD_ACC) && cnt_zero;

    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                cnt_load = 1'b1;
                if (req_write) begin
                    state_d = ST_WR_PULSE;
                    cnt_val = CW'(WR_CYC - 1);
                end else begin
                    state_d = ST_RD_ACC;
                    cnt_val = CW'(RD_CYC - 1);
                end
            end
            ST_RD_ACC: if (cnt_zero) begin
                state_d  = ST_RD_REL;
                cnt_load = 1'b1;
                cnt_val  = CW'(HZ_CYC - 1);
            end
            ST_RD_REL:   if (cnt_zero) state_d = ST_IDLE;
            ST_WR_PULSE: if (cnt_zero) state_d = ST_WR_END;
            ST_WR_END:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            strobe_q <= STROBE_IDLE;
        end else begin
            state_q  <= state_d;
            strobe_q <= strobes_for(state_d);
        end
    end

    // R4: own drivers never on while the RAM output gate is open
    p_drv_gate_excl_r4: assert property (@(posedge clk) disable iff (rst)
        strobe_q.drv |-> strobe_q.oe_n);
    // R6: write strobe rises with select still low and data still driven
    p_we_rise_held_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_q.we_n) |-> (!strobe_q.ce_n && strobe_q.drv));
    // R7: leaving idle requires a request at the previous edge
    p_accept_only_valid_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(req_ready) |-> $past(req_valid));
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 4,
    parameter int GRADE_NS      = 10,
    parameter int AW            = 17,
    parameter int DW            = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_valid,
    output logic [AW-1:0] sram_addr,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_in
);
    localparam int RD_CYC = max_of(1, max_of(ceil_div(GRADE_NS, CLK_PERIOD_NS),
                                             ceil_div(gate_access_ns(GRADE_NS), CLK_PERIOD_NS)));
    localparam int WR_CYC = max_of(1, ceil_div(GRADE_NS, CLK_PERIOD_NS));
    localparam int HZ_CYC = max_of(1, ceil_div(release_ns(GRADE_NS), CLK_PERIOD_NS));

    logic    accept, capture;
    strobe_t strobe_q;

    sram_ctl_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .HZ_CYC(HZ_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .strobe_q  (strobe_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sram_addr   <= '0;
            sram_dq_out <= '0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            if (accept) begin
                sram_addr   <= req_addr;
                sram_dq_out <= req_wdata;
            end
            rdata_valid <= capture;
            if (capture) rdata <= sram_dq_in;
        end
    end

    assign sram_ce_n  = strobe_q.ce_n;
    assign sram_oe_n  = strobe_q.oe_n;
    assign sram_we_n  = strobe_q.we_n;
    assign sram_dq_oe = strobe_q.drv;

    // R1: idle means every strobe inactive and drivers off
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));
    // R3: read-data strobe lasts a single cycle
    p_rvalid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |=> !rdata_valid);
    // R8: address frozen while the RAM is selected
    p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
    // R6: write data frozen while drivers are on
    p_wdata_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));
endmodule

// File: tb/sram_ctl_bench.sv
`timescale 1ns/100ps
module sram_ctl_bench;
    localparam int CLK_NS = 4;
    localparam int GRADE  = 10;
    localparam real T_AA  = 10.0;
    localparam real T_OE  = 5.0;
    localparam real T_HZ  = 5.0;

    function automatic int cdiv(int a, int b); return (a + b - 1) / b; endfunction
    function automatic int mx(int a, int b); return a > b ? a : b; endfunction
    localparam int N_RD = mx(1, mx(cdiv(10, CLK_NS), cdiv(5, CLK_NS)));
    localparam int N_WR = mx(1, cdiv(10, CLK_NS));
    localparam int N_HZ = mx(1, cdiv(5, CLK_NS));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rdata_valid;
    logic [7:0] rdata;
    logic [16:0] sram_addr;
    logic sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0] sram_dq_out;
    logic [7:0] bus_in = 8'hA5;

    always #(CLK_NS/2) clk = ~clk;

    sram_ctl #(.CLK_PERIOD_NS(CLK_NS), .GRADE_NS(GRADE)) u_sram_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rdata(rdata), .rdata_valid(rdata_valid), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(bus_in)
    );

    int total = 0, bad = 0;
    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] init_word(logic [16:0] a);
        return a[7:0] ^ {a[16:10], 1'b1};
    endfunction

    // ---------------- behavioural RAM model ----------------
    logic [7:0] ram_mem [logic [16:0]];
    logic [7:0] exp_mem [logic [16:0]];
    real t_addr = 0.0, t_on = 0.0, t_off = -1000.0;
    logic [16:0] last_addr = '0;
    logic act_q = 1'b0;

    function automatic logic [7:0] ram_word(logic [16:0] a);
        return ram_mem.exists(a) ? ram_mem[a] : init_word(a);
    endfunction

    initial begin
        #0.5;
        forever begin
            logic act, drv, ok;
            act = !rst && !sram_ce_n && !sram_oe_n && sram_we_n;
            if (sram_addr != last_addr) begin t_addr = $realtime; last_addr = sram_addr; end
            if (act && !act_q) t_on = $realtime;
            if (!act && act_q) t_off = $realtime;
            act_q = act;
            drv = act || (($realtime - t_off) < T_HZ);
            ok  = act && (($realtime - t_addr) >= T_AA) && (($realtime - t_on) >= T_OE);
            if (sram_dq_oe && drv) begin
                total++; bad++;
                $display("FAIL R4 bus contention actual=1 expected=0 at %0t", $time);
            end
            bus_in = drv ? (ok ? ram_word(sram_addr) : ~ram_word(sram_addr)) : 8'hA5;
            #1;
        end
    end

    always @(posedge sram_we_n) begin
        if (!rst && !sram_ce_n) begin
            chk("R6 drivers on at write edge", int'(sram_dq_oe), 1);
            ram_mem[sram_addr] = sram_dq_out;
        end
    end

    // ---------------- strobe monitor ----------------
    int oe_run = 0, we_run = 0;
    logic we_prev = 1'b1;
    logic [16:0] cur_addr = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!sram_oe_n) oe_run++;
            else if (oe_run != 0) begin chk("R2 read strobe length", oe_run, N_RD); oe_run = 0; end
            if (!sram_we_n) begin
                we_run++;
                chk("R5 gate closed during write", int'(sram_oe_n), 1);
                chk("R5 drivers on during write", int'(sram_dq_oe), 1);
            end else if (we_run != 0) begin chk("R5 write strobe length", we_run, N_WR); we_run = 0; end
            if (sram_we_n && !we_prev) chk("R6 select held after write edge", int'(sram_ce_n), 0);
            we_prev = sram_we_n;
            if (req_ready)
                chk("R1 idle strobes", int'({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}), 4'b1110);
            if (!sram_ce_n) chk("R8 address held", int'(sram_addr), int'(cur_addr));
        end
    end

    // ---------------- request tasks ----------------
    task automatic issue(bit wr, logic [16:0] a, logic [7:0] d, bit poke);
        int busy = 0, seen = 0, tmo = 0;
        logic [7:0] got = '0;
        while (!req_ready && tmo < 1000) begin tmo++; @(negedge clk); end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; cur_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && busy < 100) begin
            busy++;
            if (poke && busy == 1) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 17'h1; req_wdata = ~d;
            end
            if (poke && busy == 2) req_valid = 1'b0;
            if (rdata_valid) begin
                seen++;
                chk(wr ? "R3 no read pulse on write" : "R3 read pulse timing", busy, N_RD + 1);
                got = rdata;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (wr) begin
            chk("R6 write busy cycles", busy, N_WR + 1);
            exp_mem[a] = d;
        end else begin
            chk("R4 read busy cycles incl. release", busy, N_RD + N_HZ);
            chk("R3 one read pulse", seen, 1);
            chk("R9 read data", int'(got),
                int'(exp_mem.exists(a) ? exp_mem[a] : init_word(a)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset ready", int'(req_ready), 1);
        chk("R1 reset strobes", int'({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}), 4'b1110);
        chk("R3 reset valid", int'(rdata_valid), 0);

        // directed corners: address extremes, read-then-write turnaround
        issue(0, 17'h00000, 8'h00, 0);
        issue(1, 17'h00000, 8'h3C, 0);
        issue(0, 17'h00000, 8'h00, 0);
        issue(1, 17'h1FFFF, 8'hFF, 0);
        issue(0, 17'h1FFFF, 8'h00, 0);
        issue(1, 17'h1FFFF, 8'h81, 0);
        issue(0, 17'h1FFFF, 8'h00, 0);
        // R7: request raised and dropped while busy is ignored
        issue(0, 17'h00456, 8'h77, 1);
        issue(0, 17'h00457, 8'h00, 0);
        chk("R7 no stray write", int'(ram_mem.exists(17'h00457)), 0);
        issue(1, 17'h00800, 8'h19, 1);
        issue(0, 17'h00801, 8'h00, 0);
        chk("R7 no stray write during write", int'(ram_mem.exists(17'h00801)), 0);

        // random mix over a small address pool
        for (int i = 0; i < 400; i++) begin
            logic [16:0] a;
            logic [3:0]  sel;
            sel = 4'($urandom);
            a = {sel[3], 12'h0A0, sel[2:0], 1'b0} ^ {16'h0, sel[0]};
            issue(1'($urandom), a, 8'($urandom), 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule